// File: doc/BRIEF.md
# Configuration Done and Wake-up Controller

This block follows a programmable device through its start-up phases. The phases are initialization, configuration, wake-up and user mode, plus a terminal error phase. The bitstream loader reports to it through single-cycle strobes: a done command, an end of configuration data, and four failure flags (CRC, illegal command, non-volatile load timeout, device ID mismatch). The controller decides whether configuration succeeded, raises an internal done flag, and drives a shared open-drain done pin that has a weak pull-up.

While the device is initializing, configuring or in error, the controller pulls the done pin low. Once the internal done flag is set, it releases the pin. In the default mode the controller then goes straight on to user mode. With the external-wait option set, it reads the pin back through a synchronizer and stays in wake-up until the pin reads high. Any other device on the wire can therefore hold the whole group out of user mode until the last one has finished.

Re-initialization happens on three triggers: a power-on reset, a high-to-low edge of the asynchronous reset pin, or a refresh request. A reset pin that stays low does not hold the controller in initialization. Failure causes are kept in a sticky status word until the next initialization.

Top module: `cfg_done_ctrl`

## Requirements
- R1: After power-on reset, done_pin_oe_o is 1, int_done_o is 0, user_mode_o is 0 and err_status_o is 0. The controller spends one cycle in initialization and then waits for configuration strobes.
- R2: During configuration, a failure flag sets its sticky bit in err_status_o and moves the controller to error. The bits are: bit 0 CRC, bit 1 illegal command, bit 2 load timeout, bit 4 ID mismatch. In error, int_done_o stays 0 and done_pin_oe_o stays 1.
- R3: During configuration, end_of_data_i without done_cmd_i in the same cycle sets bit 3 (missing done command) and moves the controller to error.
- R4: During configuration, done_cmd_i with no failure in the same cycle sets int_done_o and clears done_pin_oe_o one cycle later. If a failure flag arrives in the same cycle as done_cmd_i, the failure wins.
- R5: With ext_done_en_i at 0, user_mode_o rises one cycle after int_done_o rises, whatever the level of the done pin.
- R6: With ext_done_en_i at 1, the controller stays in wake-up while the two-flop-synchronized done pin reads 0. user_mode_o rises on the third clock edge after the pin goes high.
- R7: A refresh_i pulse re-initializes the controller from any state on the next edge. A falling edge of reset_pin_n_i does the same on the third edge, after two-flop synchronization. Re-initialization sets done_pin_oe_o to 1, clears int_done_o and user_mode_o, and clears err_status_o.
- R8: Holding reset_pin_n_i low after its falling edge does not keep the controller in initialization: a later done_cmd_i still reaches user mode.
- R9: In error, err_status_o stays stable and done and end strobes are ignored until a reset-pin edge or a refresh.
- R10: Failure flags that arrive outside configuration do not change err_status_o.
- R11: user_mode_o is never 1 while int_done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reset_pin_n_i | input | 1 | Asynchronous device reset pin, acts on its falling edge |
| refresh_i | input | 1 | Refresh request, re-initializes the controller |
| done_cmd_i | input | 1 | Done command strobe from the loader |
| end_of_data_i | input | 1 | End of configuration data strobe |
| err_crc_i | input | 1 | CRC failure strobe |
| err_cmd_i | input | 1 | Illegal command strobe |
| err_timeout_i | input | 1 | Non-volatile load timeout strobe |
| err_idcode_i | input | 1 | Device ID mismatch strobe |
| ext_done_en_i | input | 1 | 1: wait in wake-up until the done pin reads high |
| done_pin_i | input | 1 | Level read back from the open-drain done pin |
| done_pin_oe_o | output | 1 | 1: pull the done pin low |
| int_done_o | output | 1 | Internal done flag |
| user_mode_o | output | 1 | Device is in user mode |
| err_status_o | output | 5 | Sticky failure causes |

## Verification
Two events can collide in one cycle: a success strobe and a failure, and any strobe and a re-initialization. The directed part of the bench provokes both. It sends done_cmd_i together with a CRC flag and expects error status 0x01 and no internal done. It also fires a refresh in error and expects the status to clear. The random phase keeps all strobes, reset-pin toggles, refreshes and an external pin holder active at once. A cycle model in the bench, built from the requirements, predicts every output at each falling edge, so cycles where several of these coincide are judged as well.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;
    typedef enum logic [2:0] {
        ST_INIT   = 3'd0,
        ST_CONFIG = 3'd1,
        ST_WAKEUP = 3'd2,
        ST_USER   = 3'd3,
        ST_ERROR  = 3'd4
    } cfg_state_e;

    localparam int ERR_W        = 5;
    localparam int ERR_CRC      = 0;
    localparam int ERR_CMD      = 1;
    localparam int ERR_TIMEOUT  = 2;
    localparam int ERR_NODONE   = 3;
    localparam int ERR_IDCODE   = 4;
endpackage

// File: rtl/cfgd_sync.sv
module cfgd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = d_i;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgd_err_latch.sv
module cfgd_err_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] sticky_d, sticky_q;

    always_comb begin
        sticky_d = sticky_q;
        if (clr_i) sticky_d = '0;
        else       sticky_d = sticky_q | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= sticky_d;
    end

    assign q_o = sticky_q;

    AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)))
        else $error("sticky bit lost"); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sticky_q == '0))
        else $error("clear ignored"); // R7
endmodule

// File: rtl/cfg_done_ctrl.sv
module cfg_done_ctrl
    import cfgd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_pin_n_i,
    input  logic             refresh_i,
    input  logic             done_cmd_i,
    input  logic             end_of_data_i,
    input  logic             err_crc_i,
    input  logic             err_cmd_i,
    input  logic             err_timeout_i,
    input  logic             err_idcode_i,
    input  logic             ext_done_en_i,
    input  logic             done_pin_i,
    output logic             done_pin_oe_o,
    output logic             int_done_o,
    output logic             user_mode_o,
    output logic [ERR_W-1:0] err_status_o
);
    typedef struct packed {
        cfg_state_e state;
        logic       rpin_prev;
    } ctrl_regs_t;

    ctrl_regs_t       regs_d, regs_q;
    logic             rpin_s;
    logic             pin_s;
    logic             init_req;
    logic             err_clr;
    logic [ERR_W-1:0] err_set;
    logic [ERR_W-1:0] cfg_flags;

    cfgd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rpin_sync (
        .clk(clk), .rst_n(rst_n), .d_i(reset_pin_n_i), .q_o(rpin_s)
    );

    cfgd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
        .clk(clk), .rst_n(rst_n), .d_i(done_pin_i), .q_o(pin_s)
    );

    cfgd_err_latch #(.W(ERR_W)) u_err (
        .clk(clk), .rst_n(rst_n), .clr_i(err_clr), .set_i(err_set),
        .q_o(err_status_o)
    );

    assign init_req = (regs_q.rpin_prev & ~rpin_s) | refresh_i;

    always_comb begin
        cfg_flags              = '0;
        cfg_flags[ERR_CRC]     = err_crc_i;
        cfg_flags[ERR_CMD]     = err_cmd_i;
        cfg_flags[ERR_TIMEOUT] = err_timeout_i;
        cfg_flags[ERR_NODONE]  = end_of_data_i & ~done_cmd_i;
        cfg_flags[ERR_IDCODE]  = err_idcode_i;
    end

    always_comb begin
        regs_d           = regs_q;
        regs_d.rpin_prev = rpin_s;
        err_clr          = 1'b0;
        err_set          = '0;
        if (init_req) begin
            regs_d.state = ST_INIT;
            err_clr      = 1'b1;
        end else begin
            case (regs_q.state)
                ST_INIT:   regs_d.state = ST_CONFIG;
                ST_CONFIG: begin
                    if (|cfg_flags) begin
                        err_set      = cfg_flags;
                        regs_d.state = ST_ERROR;
                    end else if (done_cmd_i) begin
                        regs_d.state = ST_WAKEUP;
                    end
                end
                ST_WAKEUP: begin
                    if (!ext_done_en_i || pin_s) regs_d.state = ST_USER;
                end
                ST_USER:   regs_d.state = ST_USER;
                ST_ERROR:  regs_d.state = ST_ERROR;
                default:   regs_d.state = ST_INIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state     <= ST_INIT;
            regs_q.rpin_prev <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign int_done_o    = (regs_q.state == ST_WAKEUP) || (regs_q.state == ST_USER);
    assign user_mode_o   = (regs_q.state == ST_USER);
    assign done_pin_oe_o = ~int_done_o;

    AST_USER_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode_o |-> int_done_o)
        else $error("user mode without done"); // R11
    AST_FAIL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_status_o) |-> (!int_done_o && done_pin_oe_o))
        else $error("done with failure latched"); // R2
    AST_DEFAULT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_WAKEUP && !ext_done_en_i && !init_req) |=> user_mode_o)
        else $error("default wake-up stalled"); // R5
    AST_EXT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_WAKEUP && ext_done_en_i && !pin_s && !init_req) |=> !user_mode_o)
        else $error("wake-up ignored held pin"); // R6
    AST_REFRESH_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_i |=> (done_pin_oe_o && !int_done_o && err_status_o == '0))
        else $error("refresh did not re-initialize"); // R7
    AST_ERROR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_ERROR && !init_req) |=> ($stable(err_status_o) && done_pin_oe_o))
        else $error("error state left"); // R9
endmodule

// File: tb/tb_cfg_done_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_done_ctrl;
    localparam int M_INIT = 0, M_CFG = 1, M_WAKE = 2, M_USER = 3, M_ERR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rpin = 1'b1, refresh = 1'b0, done_cmd = 1'b0, eod = 1'b0;
    logic e_crc = 1'b0, e_cmd = 1'b0, e_to = 1'b0, e_id = 1'b0;
    logic ext_en = 1'b0, hold = 1'b0;
    logic done_pin, oe, int_done, user;
    logic [4:0] err;

    int n_checks = 0;
    int n_fail = 0;
    logic model_on = 1'b0;

    always #5 clk = ~clk;

    assign done_pin = !oe && !hold;

    cfg_done_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reset_pin_n_i(rpin), .refresh_i(refresh),
        .done_cmd_i(done_cmd), .end_of_data_i(eod), .err_crc_i(e_crc),
        .err_cmd_i(e_cmd), .err_timeout_i(e_to), .err_idcode_i(e_id),
        .ext_done_en_i(ext_en), .done_pin_i(done_pin), .done_pin_oe_o(oe),
        .int_done_o(int_done), .user_mode_o(user), .err_status_o(err)
    );

    // Reference cycle model built from the requirements
    int         m_state;
    logic       m_rs1, m_rs2, m_rprev, m_ps1, m_ps2;
    logic [4:0] m_err;

    function automatic logic m_oe_f(input int st);
        return !(st == M_WAKE || st == M_USER);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= M_INIT; m_rs1 <= 1'b1; m_rs2 <= 1'b1; m_rprev <= 1'b1;
            m_ps1 <= 1'b0; m_ps2 <= 1'b0; m_err <= '0;
        end else begin
            logic       ini;
            logic [4:0] fl;
            ini = (m_rprev & ~m_rs2) | refresh;
            fl  = {e_id, eod & ~done_cmd, e_to, e_cmd, e_crc};
            m_rs1 <= rpin; m_rs2 <= m_rs1; m_rprev <= m_rs2;
            m_ps1 <= !m_oe_f(m_state) && !hold; m_ps2 <= m_ps1;
            if (ini) begin
                m_state <= M_INIT; m_err <= '0;
            end else begin
                case (m_state)
                    M_INIT: m_state <= M_CFG;
                    M_CFG: begin
                        if (|fl) begin m_err <= m_err | fl; m_state <= M_ERR; end
                        else if (done_cmd) m_state <= M_WAKE;
                    end
                    M_WAKE: if (!ext_en || m_ps2) m_state <= M_USER;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input int st);
        case (st)
            M_INIT: return "R7";
            M_CFG:  return "R2";
            M_WAKE: return "R6";
            M_USER: return "R5";
            default: return "R9";
        endcase
    endfunction

    always @(negedge clk) begin
        if (model_on) begin
            chk({tag_of(m_state), " oe"},   {31'd0, oe},       {31'd0, m_oe_f(m_state)});
            chk({tag_of(m_state), " done"}, {31'd0, int_done}, {31'd0, !m_oe_f(m_state)});
            chk({tag_of(m_state), " user"}, {31'd0, user},     {31'd0, m_state == M_USER});
            chk({tag_of(m_state), " err"},  {27'd0, err},      {27'd0, m_err});
        end
    end

    task automatic nx(input int n = 1);
        repeat (n) begin @(negedge clk); #2; end
    endtask

    task automatic pulse_done();
        done_cmd = 1'b1; nx(); done_cmd = 1'b0;
    endtask

    task automatic do_refresh();
        refresh = 1'b1; nx(); refresh = 1'b0; nx();
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        nx(3);
        rst_n = 1'b1;
        model_on = 1'b1;
        chk("R1 oe", oe, 1); chk("R1 done", int_done, 0);
        chk("R1 user", user, 0); chk("R1 err", err, 0);
        nx();
        // R4, R5: default mode
        done_cmd = 1'b1; nx(); done_cmd = 1'b0;
        chk("R4 done set", int_done, 1); chk("R4 pin released", oe, 0);
        chk("R5 not yet user", user, 0);
        nx();
        chk("R5 user", user, 1); chk("R11 user implies done", int_done, 1);
        // R10: failures in user mode ignored
        e_crc = 1'b1; e_id = 1'b1; e_to = 1'b1; nx(); e_crc = 1'b0; e_id = 1'b0; e_to = 1'b0; nx();
        chk("R10 err unchanged", err, 0); chk("R10 still user", user, 1);
        // R7: refresh from user
        refresh = 1'b1; nx(); refresh = 1'b0;
        chk("R7 refresh oe", oe, 1); chk("R7 refresh done", int_done, 0);
        nx();
        // R3: end without done
        eod = 1'b1; nx(); eod = 1'b0;
        chk("R3 nodone bit", err, 5'h08); chk("R3 oe", oe, 1);
        // R9: strobes ignored in error
        pulse_done(); eod = 1'b1; nx(); eod = 1'b0; nx();
        chk("R9 err stable", err, 5'h08); chk("R9 no done", int_done, 0);
        // R7, R8: reset pin edge, then held low
        rpin = 1'b0; nx(2);
        chk("R7 before sync", err, 5'h08);
        nx();
        chk("R7 pin edge clears", err, 0); chk("R7 pin edge oe", oe, 1);
        nx(20);
        pulse_done(); nx();
        chk("R8 held low still reaches user", user, 1);
        rpin = 1'b1; nx(4);
        // R4 collision: done and CRC together
        do_refresh();
        done_cmd = 1'b1; e_crc = 1'b1; nx(); done_cmd = 1'b0; e_crc = 1'b0;
        chk("R4 failure wins", err, 5'h01); chk("R4 no done", int_done, 0);
        // R2: each other failure bit
        do_refresh(); e_cmd = 1'b1; nx(); e_cmd = 1'b0;
        chk("R2 cmd bit", err, 5'h02);
        do_refresh(); e_to = 1'b1; nx(); e_to = 1'b0;
        chk("R2 timeout bit", err, 5'h04);
        do_refresh(); e_id = 1'b1; nx(); e_id = 1'b0;
        chk("R2 idcode bit", err, 5'h10); chk("R2 oe held", oe, 1);
        // R6: external hold
        ext_en = 1'b1; hold = 1'b1;
        do_refresh(); pulse_done(); nx(10);
        chk("R6 stalled", user, 0); chk("R6 done set", int_done, 1);
        hold = 1'b0; nx(2);
        chk("R6 two edges later", user, 0);
        nx();
        chk("R6 third edge", user, 1);
        ext_en = 1'b0;
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            refresh  = ($urandom_range(0, 63) == 0);
            done_cmd = ($urandom_range(0, 7) == 0);
            eod      = ($urandom_range(0, 29) == 0);
            e_crc    = ($urandom_range(0, 59) == 0);
            e_cmd    = ($urandom_range(0, 59) == 0);
            e_to     = ($urandom_range(0, 59) == 0);
            e_id     = ($urandom_range(0, 59) == 0);
            if ($urandom_range(0, 49) == 0) rpin = ~rpin;
            if ($urandom_range(0, 19) == 0) hold = ~hold;
            if ($urandom_range(0, 99) == 0) ext_en = ~ext_en;
            nx();
        end
        refresh = 1'b0; done_cmd = 1'b0; eod = 1'b0;
        e_crc = 1'b0; e_cmd = 1'b0; e_to = 1'b0; e_id = 1'b0;
        nx(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule